// File: doc/BRIEF.md
# Quadrature Chroma Demodulator with Tunable Subcarrier Oscillator

This block recovers the two colour-difference signals from a stream of 8-bit composite chroma samples. Each accepted sample first goes through a short symmetric band-pass filter. It is then multiplied by two locally generated subcarrier samples that are a quarter turn apart. The oscillator is a phase accumulator whose step is set by a standard-select input: a PAL-rate carrier near 4.43 MHz or an NTSC-rate carrier near 3.58 MHz, against a nominal 13.5 MHz sample rate. A hue input adds a constant offset to the oscillator phase and covers the full circle. Both step values are parameters.

The two products are rounded and clamped to signed 8 bits. Each passes through its own four-sample moving average. The results leave the block as one interleaved stream. A two-state machine (states `CH_U` and `CH_V`) chooses which filtered channel drives the output on each accepted sample. The machine moves `CH_U -> CH_V` and `CH_V -> CH_U` whenever a product pair reaches the output stage, and holds its state otherwise. A flag travels with each output word and marks it as U or V. A synchronous reset clears the accumulator, every filter history and the state machine.

Top module: `chroma_qdemod`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `out_valid`, `out_data`, `out_is_v`, the phase accumulator, the band-pass delay line and both low-pass histories. The first outputs after reset follow from that all-zero state.
- R2: A sample accepted at clock edge k (`in_valid` high) gives exactly one output word, with `out_valid` high after edge k+3. `out_valid` is low in every other cycle, and outputs keep input order.
- R3: Let x[n] be the newest accepted sample and x[n-4] the fourth-oldest, all signed. The band-pass value is b = floor((2*x[n-2] - x[n] - x[n-4]) / 4).
- R4: The 32-bit accumulator starts at 0 and adds `PAL_STEP` (std_sel=0) or `NTSC_STEP` (std_sel=1) once per accepted sample. A sample uses the accumulator value from before its own addition.
- R5: The carrier index is i = (acc[31:24] + hue) mod 256. With p = i mod 128 and m = floor(p*(128-p)*127/4096), the carrier is S(i) = m for i < 128 and -m otherwise. U uses S(i) and V uses S((i+64) mod 256).
- R6: Each product is floor((b*S + 64) / 128), clamped to the range -128..127.
- R7: Each channel's filtered value is floor((c0+c1+c2+c3)/4). Here c0 is that channel's current product and c1..c3 are its three previous products.
- R8: `out_is_v` is 0 on the first output after reset and flips on each later output. `out_data` carries the U value when the flag is 0 and the V value when it is 1.
- R9: `hue` (sampled with each accepted sample) shifts the carrier index in steps of 1/256 of a turn across the whole circle.
- R10: Cycles with `in_valid` low advance nothing. The accumulator, filter histories and U/V state hold, the `in_sample`, `std_sel` and `hue` values in those cycles have no effect, and `out_data` and `out_is_v` hold while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 8 | Signed chroma sample |
| std_sel | input | 1 | 0 selects PAL-rate step, 1 selects NTSC-rate step |
| hue | input | 8 | Phase offset, 1/256 turn per LSB |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 8 | Signed interleaved U/V value |
| out_is_v | output | 1 | 0 for a U word, 1 for a V word |

## Verification
The assertions assume that reset is high from the first clock edge. They also assume that `in_valid`, `std_sel` and `hue` are never unknown once reset is released. The latency and alternation properties rely on reset clearing the three-stage valid pipeline, so a mid-run reset is held for at least one edge. The bench changes every input half a cycle away from the sampling edge. During idle cycles it drives random junk on the data, standard and hue inputs, which keeps stimulus within these assumptions while still exercising R10.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

    // Interleave state: which filtered channel drives the next output word.
    typedef enum logic {
        CH_U = 1'b0,
        CH_V = 1'b1
    } chan_e;

    // Parabolic approximation of a sine over a 256-step circle, amplitude 127.
    function automatic logic signed [7:0] par_sine(input logic [7:0] idx);
        logic [6:0]  p;
        logic [7:0]  q;
        logic [21:0] t;
        logic signed [7:0] mag;
        p   = idx[6:0];
        q   = 8'd128 - {1'b0, p};
        t   = 22'(p) * 22'(q) * 22'd127;
        mag = 8'(t >> 12);
        return idx[7] ? -mag : mag;
    endfunction

endpackage

// File: rtl/cqd_dto.sv
module cqd_dto #(
    parameter int                ACC_W     = 32,
    parameter int                IDX_W     = 8,
    parameter logic [ACC_W-1:0]  PAL_STEP  = 32'd1410536854,
    parameter logic [ACC_W-1:0]  NTSC_STEP = 32'd1138816948
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    std_sel,
    input  logic [IDX_W-1:0]        hue,
    output logic signed [7:0]       sin_q,
    output logic signed [7:0]       cos_q
);
    import cqd_pkg::*;

    localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1 << (IDX_W - 2));

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        step = std_sel ? NTSC_STEP : PAL_STEP;
    end

    // Stage 1: accumulate phase and latch the offset index for this sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            idx_q <= '0;
        end else if (step_en) begin
            acc   <= acc + step;
            idx_q <= acc[ACC_W-1 -: IDX_W] + hue;
        end
    end

    // Stage 2: quadrature carrier samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= par_sine(idx_q);
            cos_q <= par_sine(idx_q + QUARTER);
        end
    end

    // R10: the phase stays put when no sample is accepted.
    a_r10_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(acc))
        else $error("phase accumulator moved without a sample");

    // R5: at a carrier peak the quadrature carrier crosses zero.
    always_comb begin
        if (rst == 1'b0 && (sin_q == 8'sd127 || sin_q == -8'sd127)) begin
            a_r5_quadrature: assert (cos_q == 8'sd0)
                else $error("carriers are not in quadrature");
        end
    end

endmodule

// File: rtl/cqd_bpf.sv
module cqd_bpf #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] bp_q
);
    localparam int NTAP = 5;
    localparam int SW   = DATA_W + 2;

    logic signed [DATA_W-1:0] tap [NTAP];
    logic signed [SW-1:0]     acc;

    // Delay line, newest sample in tap[0].
    always_ff @(posedge clk) begin
        if (rst) begin
            tap[0] <= '0;
        end else if (shift_en) begin
            tap[0] <= din;
        end
    end

    for (genvar k = 1; k < NTAP; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                tap[k] <= '0;
            end else if (shift_en) begin
                tap[k] <= tap[k-1];
            end
        end
    end

    // Symmetric kernel [-1 0 2 0 -1] / 4, floor by arithmetic shift.
    always_comb begin
        acc = (SW'(tap[2]) <<< 1) - SW'(tap[0]) - SW'(tap[NTAP-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q <= '0;
        end else begin
            bp_q <= acc[SW-1:2];
        end
    end

    // R10: the delay line is untouched while no sample arrives.
    a_r10_taps_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(tap[0]) && $stable(tap[NTAP-1]))
        else $error("band-pass history moved without a sample");

endmodule

// File: rtl/cqd_mix.sv
module cqd_mix #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] bp,
    input  logic signed [DATA_W-1:0] car,
    output logic signed [DATA_W-1:0] prod_q
);
    localparam int PW   = 2 * DATA_W;
    localparam int FRAC = DATA_W - 1;
    localparam logic signed [PW:0] HALF = (PW+1)'(1 << (FRAC - 1));
    localparam logic signed [PW:0] HI   = (PW+1)'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PW:0] LO   = -HI - (PW+1)'(1);

    logic signed [PW-1:0] full;
    logic signed [PW:0]   rnd;
    logic signed [PW:0]   sh;
    logic signed [PW:0]   sat;

    always_comb begin
        full = PW'(bp) * PW'(car);
        rnd  = (PW+1)'(full) + HALF;
        sh   = rnd >>> FRAC;
        if (sh > HI) begin
            sat = HI;
        end else if (sh < LO) begin
            sat = LO;
        end else begin
            sat = sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q <= sat[DATA_W-1:0];
        end
    end

    // R6: a zero operand gives a zero product on the next edge.
    a_r6_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (bp == '0 || car == '0) |=> (prod_q == '0))
        else $error("zero operand gave a nonzero product");

endmodule

// File: rtl/cqd_lpf_out.sv
module cqd_lpf_out #(
    parameter int DATA_W = 8,
    parameter int TAPS   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pair_valid,
    input  logic signed [DATA_W-1:0] pu,
    input  logic signed [DATA_W-1:0] pv,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     out_is_v
);
    import cqd_pkg::*;

    localparam int SH  = $clog2(TAPS);
    localparam int SW  = DATA_W + SH;
    localparam int HL  = TAPS - 1;

    logic signed [DATA_W-1:0] hu [HL];
    logic signed [DATA_W-1:0] hv [HL];
    logic signed [SW-1:0]     sum_u;
    logic signed [SW-1:0]     sum_v;
    logic signed [DATA_W-1:0] avg_u;
    logic signed [DATA_W-1:0] avg_v;

    chan_e state;
    chan_e state_nx;

    // Moving-average histories, one per channel.
    always_ff @(posedge clk) begin
        if (rst) begin
            hu[0] <= '0;
            hv[0] <= '0;
        end else if (pair_valid) begin
            hu[0] <= pu;
            hv[0] <= pv;
        end
    end

    for (genvar k = 1; k < HL; k++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) begin
                hu[k] <= '0;
                hv[k] <= '0;
            end else if (pair_valid) begin
                hu[k] <= hu[k-1];
                hv[k] <= hv[k-1];
            end
        end
    end

    always_comb begin
        sum_u = SW'(pu);
        sum_v = SW'(pv);
        for (int k = 0; k < HL; k++) begin
            sum_u = sum_u + SW'(hu[k]);
            sum_v = sum_v + SW'(hv[k]);
        end
        avg_u = sum_u[SW-1:SH];
        avg_v = sum_v[SW-1:SH];
    end

    // Next-state logic of the interleave machine.
    always_comb begin
        state_nx = state;
        if (pair_valid) begin
            unique case (state)
                CH_U: state_nx = CH_V;
                CH_V: state_nx = CH_U;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_U;
        end else begin
            state <= state_nx;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_is_v  <= 1'b0;
        end else begin
            out_valid <= pair_valid;
            if (pair_valid) begin
                unique case (state)
                    CH_U: begin
                        out_data <= avg_u;
                        out_is_v <= 1'b0;
                    end
                    CH_V: begin
                        out_data <= avg_v;
                        out_is_v <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R8: back-to-back words alternate between U and V.
    a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_is_v != $past(out_is_v)))
        else $error("U/V flag failed to alternate");

    // R10: output word and flag hold while no pair arrives.
    a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |=> $stable(out_data) && $stable(out_is_v))
        else $error("output changed without a new pair");

endmodule

// File: rtl/chroma_qdemod.sv
module chroma_qdemod #(
    parameter int                DATA_W    = 8,
    parameter int                ACC_W     = 32,
    parameter int                IDX_W     = 8,
    parameter int                LPF_TAPS  = 4,
    parameter logic [ACC_W-1:0]  PAL_STEP  = 32'd1410536854,
    parameter logic [ACC_W-1:0]  NTSC_STEP = 32'd1138816948
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     std_sel,
    input  logic [IDX_W-1:0]         hue,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     out_is_v
);
    localparam int NCH   = 2;
    localparam int DEPTH = 3;

    logic [DEPTH-1:0]         vpipe;
    logic signed [DATA_W-1:0] bp_q;
    logic signed [7:0]        sin_q;
    logic signed [7:0]        cos_q;
    logic signed [DATA_W-1:0] car  [NCH];
    logic signed [DATA_W-1:0] prod [NCH];

    // Valid tags follow the samples through the three data stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[DEPTH-2:0], in_valid};
        end
    end

    cqd_dto #(
        .ACC_W    (ACC_W),
        .IDX_W    (IDX_W),
        .PAL_STEP (PAL_STEP),
        .NTSC_STEP(NTSC_STEP)
    ) u_dto (
        .clk    (clk),
        .rst    (rst),
        .step_en(in_valid),
        .std_sel(std_sel),
        .hue    (hue),
        .sin_q  (sin_q),
        .cos_q  (cos_q)
    );

    cqd_bpf #(
        .DATA_W(DATA_W)
    ) u_bpf (
        .clk     (clk),
        .rst     (rst),
        .shift_en(in_valid),
        .din     (in_sample),
        .bp_q    (bp_q)
    );

    always_comb begin
        car[0] = DATA_W'(sin_q);
        car[1] = DATA_W'(cos_q);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mix
        cqd_mix #(
            .DATA_W(DATA_W)
        ) u_mix (
            .clk   (clk),
            .rst   (rst),
            .bp    (bp_q),
            .car   (car[c]),
            .prod_q(prod[c])
        );
    end

    cqd_lpf_out #(
        .DATA_W(DATA_W),
        .TAPS  (LPF_TAPS)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .pair_valid(vpipe[DEPTH-1]),
        .pu        (prod[0]),
        .pv        (prod[1]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_is_v  (out_is_v)
    );

    // R2: an accepted sample surfaces after edge k+3.
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##3 out_valid)
        else $error("accepted sample did not reach the output in time");

    // R2: no output word without a matching sample.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##3 !out_valid)
        else $error("output word without an accepted sample");

    // R1: reset leaves the output idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid && out_data == '0 && !out_is_v)
        else $error("outputs not cleared by reset");

endmodule

// File: tb/tb_chroma_qdemod.sv
module tb_chroma_qdemod;

    localparam logic [31:0] PAL_S  = 32'd1410536854;
    localparam logic [31:0] NTSC_S = 32'd1138816948;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic              std_sel = 1'b0;
    logic [7:0]        hue = '0;
    logic              out_valid;
    logic signed [7:0] out_data;
    logic              out_is_v;

    chroma_qdemod dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .std_sel  (std_sel),
        .hue      (hue),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_is_v (out_is_v)
    );

    always #4 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";

    // Reference model state.
    int          mt [5];
    logic [31:0] macc;
    int          mhu [3];
    int          mhv [3];
    bit          mtog;
    int          exp_d [$];
    bit          exp_v [$];
    int          last_d;

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, expv);
        end
    endtask

    function automatic int sinf(input int idx);
        int p;
        int m;
        p = idx % 128;
        m = (p * (128 - p) * 127) / 4096;
        return (idx >= 128) ? -m : m;
    endfunction

    function automatic int mixr(input int b, input int c);
        int r;
        r = (b * c + 64) >>> 7;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 5; i++) mt[i] = 0;
        for (int i = 0; i < 3; i++) begin
            mhu[i] = 0;
            mhv[i] = 0;
        end
        macc = '0;
        mtog = 1'b0;
        exp_d.delete();
        exp_v.delete();
    endtask

    task automatic model_push(input int x, input bit sd, input int h);
        int b, idx, pu, pv, au, av;
        for (int i = 4; i > 0; i--) mt[i] = mt[i-1];
        mt[0] = x;
        b   = (2 * mt[2] - mt[0] - mt[4]) >>> 2;
        idx = (int'(macc[31:24]) + h) % 256;
        macc = macc + (sd ? NTSC_S : PAL_S);
        pu = mixr(b, sinf(idx));
        pv = mixr(b, sinf((idx + 64) % 256));
        au = (pu + mhu[0] + mhu[1] + mhu[2]) >>> 2;
        av = (pv + mhv[0] + mhv[1] + mhv[2]) >>> 2;
        mhu[2] = mhu[1]; mhu[1] = mhu[0]; mhu[0] = pu;
        mhv[2] = mhv[1]; mhv[1] = mhv[0]; mhv[0] = pv;
        exp_d.push_back(mtog ? av : au);
        exp_v.push_back(mtog);
        mtog = ~mtog;
    endtask

    task automatic send(input int x, input bit sd, input int h);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'(x);
        std_sel   = sd;
        hue       = 8'(h);
        model_push(x, sd, h);
    endtask

    // Idle cycles with junk on the ignored inputs (R10).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 8'($urandom);
            std_sel   = 1'($urandom);
            hue       = 8'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(out_data == 8'sd0, "R1", "out_data in reset", int'(out_data), 0);
        chk(out_is_v == 1'b0, "R1", "out_is_v in reset", int'(out_is_v), 0);
        model_clear();
        rst = 1'b0;
    endtask

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            last_d = 0;
        end else if (out_valid) begin
            if (exp_d.size() == 0) begin
                chk(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                int ed;
                bit ev;
                ed = exp_d.pop_front();
                ev = exp_v.pop_front();
                chk(int'(out_data) == ed, cur_req, "out_data", int'(out_data), ed);
                chk(out_is_v == ev, "R8", "out_is_v", int'(out_is_v), int'(ev));
            end
            last_d = int'(out_data);
        end else begin
            chk(int'(out_data) == last_d, "R10", "out_data hold", int'(out_data), last_d);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired got=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        last_d = 0;

        // R1: reset state and first outputs from a cleared state.
        cur_req = "R1";
        do_reset();
        for (int i = 0; i < 8; i++) send(40 - 11 * i, 1'b0, 0);
        idle(6);

        // R2: latency of exactly three edges after acceptance.
        cur_req = "R2";
        do_reset();
        send(100, 1'b0, 0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == (k == 4), "R2", "out_valid timing", int'(out_valid), int'(k == 4));
        end

        // R3: impulse and alternating patterns through the band-pass.
        cur_req = "R3";
        do_reset();
        send(127, 1'b0, 0);
        for (int i = 0; i < 6; i++) send(0, 1'b0, 0);
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 90 : -90, 1'b0, 0);
        idle(6);

        // R5: carrier shape across hue settings at a fixed input.
        cur_req = "R5";
        for (int h = 0; h < 256; h += 16) begin
            do_reset();
            for (int i = 0; i < 6; i++) send((i % 2 == 0) ? 127 : -128, 1'b0, h);
            idle(5);
        end

        // R6: full-scale products at the rounding and clamp edges.
        cur_req = "R6";
        do_reset();
        for (int i = 0; i < 40; i++) send((i % 4 < 2) ? -128 : 127, 1'b0, 64);
        idle(5);

        // R7: step input settling through the moving average.
        cur_req = "R7";
        do_reset();
        for (int i = 0; i < 30; i++) send((i < 10) ? 0 : ((i % 2 == 0) ? 60 : -60), 1'b0, 32);
        idle(5);

        // R4: NTSC step and switching between standards.
        cur_req = "R4";
        do_reset();
        for (int i = 0; i < 400; i++)
            send($signed(8'($urandom)), (i / 50) % 2 == 0, 0);
        idle(5);

        // R9: random hue across the whole circle.
        cur_req = "R9";
        do_reset();
        for (int i = 0; i < 400; i++)
            send($signed(8'($urandom)), 1'($urandom), int'(8'($urandom)));
        idle(5);

        // R10: random gaps with junk on ignored inputs.
        cur_req = "R10";
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            send($signed(8'($urandom)), 1'($urandom), int'(8'($urandom)));
            if ($urandom % 3 == 0) idle(1 + int'($urandom % 4));
        end
        idle(6);

        // R2: mid-stream reset drops pending words; nothing left over.
        cur_req = "R1";
        for (int i = 0; i < 3; i++) send(50, 1'b0, 0);
        do_reset();
        idle(6);
        chk(exp_d.size() == 0, "R2", "pending outputs", exp_d.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule